// File: doc/BRIEF.md
# Circular Store Queue Controller

This block keeps the stores of one thread in program order, in a circular buffer. A store takes the tail slot when it is allocated. The slot index goes back to the pipeline, which later fills in the address, byte count and data. The commit stage then marks stores as committed by sequence number. A writeback pointer sits between the head and the tail. It sends committed stores that have their data, one at a time and in order, over a valid/ready request channel. A slot is released only after memory returns a completion pulse for that slot.

Completions may arrive out of order. The head moves past a slot only once that slot is marked completed, so an early completion waits until every older store has also completed. A squash drops every store younger than a given sequence number by pulling the tail back. One slot always stays empty as a sentinel, so the queue holds at most `ENTRIES-1` stores. A counter tracks stores that are committed but not yet sent, and the block outputs it both as a count and as a non-zero flag.

Top module: `store_queue_ctrl`

## Requirements
- R1: After synchronous reset the queue is empty: `count`=0, `full`=0, `mem_req_valid`=0, `wb_pending`=0, `wb_pending_cnt`=0 and `mem_blocked`=0.
- R2: `alloc_idx` always shows the current tail slot. An accepted allocation takes that slot, and slots are handed out in increasing order, wrapping from `ENTRIES-1` back to 0.
- R3: `full` is 1 exactly when `count` equals `ENTRIES-1`. An allocation offered while `full` is 1 is ignored and `count` is left unchanged.
- R4: A request is raised only for the slot at the writeback pointer, and only when that slot has had its data written and has been committed. Requests go out in allocation order, and an uncommitted store is never requested.
- R5: A commit pulse marks as committed every live store whose sequence number is less than or equal to `commit_seq`, using unsigned comparison. `wb_pending_cnt` grows by the number of stores newly committed, and `wb_pending` is 1 whenever that count is non-zero.
- R6: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays valid with the same slot, address, size and data. `mem_blocked` is 1 from the next cycle until ready is seen, and `will_wb` is 0 while blocked.
- R7: Neither commit nor a request handshake frees a slot. `count` drops only after completion pulses arrive.
- R8: A completion pulse for a slot that is not the head frees nothing. Once the head slot completes, the head advances one completed slot per cycle.
- R9: A squash removes all live stores whose sequence number is greater than `squash_seq`, and the next allocation reuses the first removed slot. An allocation offered in the same cycle as a squash is ignored.
- R10: When a commit pulse and a request handshake fall in the same cycle, `wb_pending_cnt` becomes old + newly committed − 1.
- R11: The request carries the address, byte count (0 to 16) and data last written to that slot, along with the slot index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocate a new store at the tail |
| alloc_seq | input | SEQ_W | Sequence number of the new store |
| alloc_idx | output | IDX_W | Slot the next allocation takes |
| full | output | 1 | Queue holds ENTRIES-1 stores |
| count | output | CNT_W | Number of live stores |
| wr_valid | input | 1 | Write store address and data into a slot |
| wr_idx | input | IDX_W | Slot being written |
| wr_addr | input | ADDR_W | Store address |
| wr_size | input | SIZE_W | Store byte count, 0 to 16 |
| wr_data | input | 8*DATA_BYTES | Store data bytes |
| commit_valid | input | 1 | Commit pulse |
| commit_seq | input | SEQ_W | Youngest sequence number being committed |
| squash_valid | input | 1 | Squash pulse |
| squash_seq | input | SEQ_W | Stores younger than this are removed |
| mem_req_valid | output | 1 | Write request to memory |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_idx | output | IDX_W | Slot of the request |
| mem_req_addr | output | ADDR_W | Address of the request |
| mem_req_size | output | SIZE_W | Byte count of the request |
| mem_req_data | output | 8*DATA_BYTES | Data of the request |
| mem_ack | input | 1 | Completion pulse from memory |
| mem_ack_idx | input | IDX_W | Slot that completed |
| mem_blocked | output | 1 | Last request offer was rejected |
| will_wb | output | 1 | A request is offered and not blocked |
| wb_pending | output | 1 | Some committed store is still unsent |
| wb_pending_cnt | output | CNT_W | Committed stores not yet sent |

## Verification
Commit and request handshake can land in the same cycle, and both change the pending-writeback count: one adds and the other subtracts. The bench sets this up by holding `mem_req_ready` low until a request is blocked. It then raises ready in the same cycle as a commit pulse for one more store, and requires the count to stay at its old value, since the commit adds one and the handshake removes one. Squash and allocation can also coincide. The bench offers both together and requires `count` and the next `alloc_idx` to show that only the squash took effect.

// File: rtl/sq_pkg.sv
package sq_pkg;

    localparam int DEF_ENTRIES    = 8;
    localparam int DEF_SEQ_W      = 16;
    localparam int DEF_ADDR_W     = 32;
    localparam int DEF_DATA_BYTES = 16;

    typedef struct packed {
        logic can_wb;
        logic committed;
        logic completed;
    } sq_flags_t;

    function automatic int next_slot(int cur, int n);
        return (cur + 1 == n) ? 0 : cur + 1;
    endfunction

    function automatic int slot_add(int base, int off, int n);
        return (base + off) % n;
    endfunction

endpackage

// File: rtl/sq_pointers.sv
module sq_pointers #(
    parameter int ENTRIES = sq_pkg::DEF_ENTRIES,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int CNT_W  = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc_fire,
    input  logic             squash_fire,
    input  logic [CNT_W-1:0] squash_len,
    input  logic             issue_fire,
    input  logic             free_fire,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic [IDX_W-1:0] wbp,
    output logic [CNT_W-1:0] count,
    output logic             live [ENTRIES]
);
    import sq_pkg::*;

    logic [IDX_W-1:0] head_q, tail_q, wbp_q;
    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q  <= '0;
            tail_q  <= '0;
            wbp_q   <= '0;
            count_q <= '0;
        end else begin
            if (free_fire)
                head_q <= IDX_W'(next_slot(int'(head_q), ENTRIES));
            if (issue_fire)
                wbp_q <= IDX_W'(next_slot(int'(wbp_q), ENTRIES));
            if (squash_fire) begin
                tail_q  <= IDX_W'(slot_add(int'(head_q), int'(squash_len), ENTRIES));
                count_q <= squash_len - CNT_W'(free_fire);
            end else begin
                if (alloc_fire)
                    tail_q <= IDX_W'(next_slot(int'(tail_q), ENTRIES));
                count_q <= count_q + CNT_W'(alloc_fire) - CNT_W'(free_fire);
            end
        end
    end

    always_comb begin
        int off;
        for (int i = 0; i < ENTRIES; i++) begin
            off     = (i - int'(head_q) + ENTRIES) % ENTRIES;
            live[i] = off < int'(count_q);
        end
    end

    assign head  = head_q;
    assign tail  = tail_q;
    assign wbp   = wbp_q;
    assign count = count_q;

endmodule

// File: rtl/sq_entry_array.sv
module sq_entry_array #(
    parameter int ENTRIES    = sq_pkg::DEF_ENTRIES,
    parameter int SEQ_W      = sq_pkg::DEF_SEQ_W,
    parameter int ADDR_W     = sq_pkg::DEF_ADDR_W,
    parameter int DATA_BYTES = sq_pkg::DEF_DATA_BYTES,
    localparam int IDX_W     = $clog2(ENTRIES),
    localparam int CNT_W     = IDX_W + 1,
    localparam int SIZE_W    = $clog2(DATA_BYTES + 1),
    localparam int DATA_W    = 8 * DATA_BYTES
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  alloc_fire,
    input  logic [IDX_W-1:0]      alloc_slot,
    input  logic [SEQ_W-1:0]      alloc_seq,
    input  logic                  wr_valid,
    input  logic [IDX_W-1:0]      wr_slot,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [SIZE_W-1:0]     wr_size,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  commit_valid,
    input  logic [SEQ_W-1:0]      commit_seq,
    input  logic                  live [ENTRIES],
    input  logic                  ack_valid,
    input  logic [IDX_W-1:0]      ack_slot,
    output sq_pkg::sq_flags_t     flags  [ENTRIES],
    output logic [SEQ_W-1:0]      seq    [ENTRIES],
    output logic [ADDR_W-1:0]     addr   [ENTRIES],
    output logic [SIZE_W-1:0]     size   [ENTRIES],
    output logic [DATA_W-1:0]     data   [ENTRIES],
    output logic [CNT_W-1:0]      new_commits
);
    import sq_pkg::*;

    logic commit_hit [ENTRIES];

    always_comb begin
        int n;
        n = 0;
        for (int i = 0; i < ENTRIES; i++) begin
            commit_hit[i] = commit_valid && live[i] && !flags[i].committed
                            && (seq[i] <= commit_seq);
            if (commit_hit[i])
                n++;
        end
        new_commits = CNT_W'(n);
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                flags[g] <= '0;
                seq[g]   <= '0;
                addr[g]  <= '0;
                size[g]  <= '0;
                data[g]  <= '0;
            end else begin
                if (commit_hit[g])
                    flags[g].committed <= 1'b1;
                if (ack_valid && ack_slot == IDX_W'(g))
                    flags[g].completed <= 1'b1;
                if (wr_valid && wr_slot == IDX_W'(g)) begin
                    addr[g]         <= wr_addr;
                    size[g]         <= wr_size;
                    data[g]         <= wr_data;
                    flags[g].can_wb <= 1'b1;
                end
                if (alloc_fire && alloc_slot == IDX_W'(g)) begin
                    seq[g]   <= alloc_seq;
                    size[g]  <= '0;
                    flags[g] <= '0;
                end
            end
        end
    end

endmodule

// File: rtl/sq_wb_port.sv
module sq_wb_port #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_ready,
    input  logic [CNT_W-1:0] new_commits,
    output logic             blocked,
    output logic [CNT_W-1:0] pend_cnt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            blocked  <= 1'b0;
            pend_cnt <= '0;
        end else begin
            blocked  <= req_valid && !req_ready;
            pend_cnt <= pend_cnt + new_commits - CNT_W'(req_valid && req_ready);
        end
    end
endmodule

// File: rtl/store_queue_ctrl.sv
module store_queue_ctrl #(
    parameter int ENTRIES    = sq_pkg::DEF_ENTRIES,
    parameter int SEQ_W      = sq_pkg::DEF_SEQ_W,
    parameter int ADDR_W     = sq_pkg::DEF_ADDR_W,
    parameter int DATA_BYTES = sq_pkg::DEF_DATA_BYTES,
    localparam int IDX_W     = $clog2(ENTRIES),
    localparam int CNT_W     = IDX_W + 1,
    localparam int SIZE_W    = $clog2(DATA_BYTES + 1),
    localparam int DATA_W    = 8 * DATA_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_valid,
    input  logic [SEQ_W-1:0]  alloc_seq,
    output logic [IDX_W-1:0]  alloc_idx,
    output logic              full,
    output logic [CNT_W-1:0]  count,
    input  logic              wr_valid,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [SIZE_W-1:0] wr_size,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              commit_valid,
    input  logic [SEQ_W-1:0]  commit_seq,
    input  logic              squash_valid,
    input  logic [SEQ_W-1:0]  squash_seq,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [IDX_W-1:0]  mem_req_idx,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [SIZE_W-1:0] mem_req_size,
    output logic [DATA_W-1:0] mem_req_data,
    input  logic              mem_ack,
    input  logic [IDX_W-1:0]  mem_ack_idx,
    output logic              mem_blocked,
    output logic              will_wb,
    output logic              wb_pending,
    output logic [CNT_W-1:0]  wb_pending_cnt
);
    import sq_pkg::*;

    logic [IDX_W-1:0]  head, tail, wbp;
    logic              live [ENTRIES];
    sq_flags_t         flags [ENTRIES];
    logic [SEQ_W-1:0]  seq   [ENTRIES];
    logic [ADDR_W-1:0] addr  [ENTRIES];
    logic [SIZE_W-1:0] size  [ENTRIES];
    logic [DATA_W-1:0] data  [ENTRIES];
    logic [CNT_W-1:0]  new_commits;
    logic [CNT_W-1:0]  squash_len;
    logic              alloc_fire, issue_ok, issue_fire, free_fire;

    assign full       = count >= CNT_W'(ENTRIES - 1);
    assign alloc_fire = alloc_valid && !full && !squash_valid;
    assign alloc_idx  = tail;

    // Oldest live store younger than the squash point becomes the new tail.
    always_comb begin
        int  slot;
        logic found;
        squash_len = count;
        found      = 1'b0;
        for (int k = 0; k < ENTRIES; k++) begin
            slot = slot_add(int'(head), k, ENTRIES);
            if (!found && k < int'(count) && seq[slot] > squash_seq) begin
                squash_len = CNT_W'(k);
                found      = 1'b1;
            end
        end
    end

    assign issue_ok   = (wbp != tail) && flags[wbp].can_wb && flags[wbp].committed
                        && !flags[wbp].completed;
    assign issue_fire = issue_ok && mem_req_ready;
    assign free_fire  = (count != '0) && (head != wbp) && flags[head].completed;

    sq_pointers #(.ENTRIES(ENTRIES)) u_ptrs (
        .clk        (clk),
        .rst        (rst),
        .alloc_fire (alloc_fire),
        .squash_fire(squash_valid),
        .squash_len (squash_len),
        .issue_fire (issue_fire),
        .free_fire  (free_fire),
        .head       (head),
        .tail       (tail),
        .wbp        (wbp),
        .count      (count),
        .live       (live)
    );

    sq_entry_array #(
        .ENTRIES(ENTRIES), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES)
    ) u_array (
        .clk         (clk),
        .rst         (rst),
        .alloc_fire  (alloc_fire),
        .alloc_slot  (tail),
        .alloc_seq   (alloc_seq),
        .wr_valid    (wr_valid),
        .wr_slot     (wr_idx),
        .wr_addr     (wr_addr),
        .wr_size     (wr_size),
        .wr_data     (wr_data),
        .commit_valid(commit_valid),
        .commit_seq  (commit_seq),
        .live        (live),
        .ack_valid   (mem_ack),
        .ack_slot    (mem_ack_idx),
        .flags       (flags),
        .seq         (seq),
        .addr        (addr),
        .size        (size),
        .data        (data),
        .new_commits (new_commits)
    );

    sq_wb_port #(.CNT_W(CNT_W)) u_wb (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (issue_ok),
        .req_ready  (mem_req_ready),
        .new_commits(new_commits),
        .blocked    (mem_blocked),
        .pend_cnt   (wb_pending_cnt)
    );

    assign mem_req_valid = issue_ok;
    assign mem_req_idx   = wbp;
    assign mem_req_addr  = addr[wbp];
    assign mem_req_size  = size[wbp];
    assign mem_req_data  = data[wbp];
    assign will_wb       = issue_ok && !mem_blocked;
    assign wb_pending    = wb_pending_cnt != '0;

endmodule

// File: rtl/sq_checker.sv
module sq_checker #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3,
    parameter int CNT_W   = 4,
    parameter int ADDR_W  = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              full,
    input logic [CNT_W-1:0]  count,
    input logic              commit_valid,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [IDX_W-1:0]  mem_req_idx,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_blocked,
    input logic              will_wb,
    input logic [CNT_W-1:0]  wb_pending_cnt
);
    p_count_cap_r3: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(ENTRIES - 1));

    p_full_no_grow_r3: assert property (@(posedge clk) disable iff (rst)
        full |=> count <= $past(count));

    p_req_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_idx) && $stable(mem_req_addr)));

    p_blocked_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_blocked && !will_wb));

    p_empty_no_req_r4: assert property (@(posedge clk) disable iff (rst)
        (count == '0) |-> !mem_req_valid);

    p_pend_no_rise_r5: assert property (@(posedge clk) disable iff (rst)
        !commit_valid |=> wb_pending_cnt <= $past(wb_pending_cnt));
endmodule

bind store_queue_ctrl sq_checker #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) u_sq_checker (
    .clk           (clk),
    .rst           (rst),
    .full          (full),
    .count         (count),
    .commit_valid  (commit_valid),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_idx   (mem_req_idx),
    .mem_req_addr  (mem_req_addr),
    .mem_blocked   (mem_blocked),
    .will_wb       (will_wb),
    .wb_pending_cnt(wb_pending_cnt)
);

// File: tb/store_queue_ctrl_tb.sv
module store_queue_ctrl_tb;
    localparam int CLK_P = 10;
    localparam int E     = 8;

    logic         clk = 0;
    logic         rst = 1;
    logic         alloc_valid = 0;
    logic [15:0]  alloc_seq = 0;
    logic [2:0]   alloc_idx;
    logic         full;
    logic [3:0]   count;
    logic         wr_valid = 0;
    logic [2:0]   wr_idx = 0;
    logic [31:0]  wr_addr = 0;
    logic [4:0]   wr_size = 0;
    logic [127:0] wr_data = 0;
    logic         commit_valid = 0;
    logic [15:0]  commit_seq = 0;
    logic         squash_valid = 0;
    logic [15:0]  squash_seq = 0;
    logic         mem_req_valid;
    logic         mem_req_ready = 0;
    logic [2:0]   mem_req_idx;
    logic [31:0]  mem_req_addr;
    logic [4:0]   mem_req_size;
    logic [127:0] mem_req_data;
    logic         mem_ack = 0;
    logic [2:0]   mem_ack_idx = 0;
    logic         mem_blocked, will_wb, wb_pending;
    logic [3:0]   wb_pending_cnt;

    always #(CLK_P/2) clk = ~clk;

    store_queue_ctrl u_dut (.*);

    typedef struct {
        logic [2:0]   idx;
        logic [31:0]  addr;
        logic [4:0]   size;
        logic [127:0] data;
    } exp_t;
    exp_t exp_q[$];

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_alloc(logic [15:0] s, logic [2:0] exp_idx);
        alloc_valid = 1; alloc_seq = s;
        #1 check("R2 alloc slot", 128'(alloc_idx), 128'(exp_idx));
        tick();
        alloc_valid = 0;
    endtask

    task automatic do_write(logic [2:0] i, logic [31:0] a, logic [4:0] sz, logic [127:0] d);
        exp_t e;
        wr_valid = 1; wr_idx = i; wr_addr = a; wr_size = sz; wr_data = d;
        e.idx = i; e.addr = a; e.size = sz; e.data = d;
        exp_q.push_back(e);
        tick();
        wr_valid = 0;
    endtask

    task automatic do_commit(logic [15:0] s);
        commit_valid = 1; commit_seq = s;
        tick();
        commit_valid = 0;
    endtask

    task automatic do_ack(logic [2:0] i);
        mem_ack = 1; mem_ack_idx = i;
        tick();
        mem_ack = 0;
    endtask

    // Scoreboard monitor: samples a quarter period after the falling edge.
    always @(negedge clk) begin
        #(CLK_P/4);
        if (!rst && mem_req_valid && mem_req_ready) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R4 unexpected request idx=%0d expected none", mem_req_idx);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check("R4 request order", 128'(mem_req_idx), 128'(e.idx));
                check("R11 request addr", 128'(mem_req_addr), 128'(e.addr));
                check("R11 request size", 128'(mem_req_size), 128'(e.size));
                check("R11 request data", mem_req_data, e.data);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 0;
        check("R1 count", 128'(count), 0);
        check("R1 full", 128'(full), 0);
        check("R1 req_valid", 128'(mem_req_valid), 0);
        check("R1 pending", 128'(wb_pending), 0);
        check("R1 pending cnt", 128'(wb_pending_cnt), 0);
        check("R1 blocked", 128'(mem_blocked), 0);

        do_alloc(16'd10, 3'd0);
        do_alloc(16'd11, 3'd1);
        do_alloc(16'd12, 3'd2);
        check("R2 count after allocs", 128'(count), 3);
        do_write(3'd0, 32'h1000, 5'd4,  {4{32'hA0A0_0001}});
        do_write(3'd1, 32'h1004, 5'd16, {4{32'hB1B1_0002}});
        do_write(3'd2, 32'h2001, 5'd1,  {4{32'hC2C2_0003}});
        check("R4 uncommitted not requested", 128'(mem_req_valid), 0);

        do_commit(16'd11);
        check("R5 pending cnt", 128'(wb_pending_cnt), 2);
        check("R5 pending flag", 128'(wb_pending), 1);
        check("R4 request at head", 128'(mem_req_valid), 1);
        tick();
        check("R6 blocked", 128'(mem_blocked), 1);
        check("R6 will_wb low", 128'(will_wb), 0);
        check("R7 no free on commit", 128'(count), 3);

        // commit and handshake land together
        commit_valid = 1; commit_seq = 16'd12; mem_req_ready = 1;
        tick();
        commit_valid = 0;
        check("R10 pending after commit+issue", 128'(wb_pending_cnt), 2);
        repeat (3) tick();
        check("R10 pending drained", 128'(wb_pending_cnt), 0);
        check("R5 pending flag clear", 128'(wb_pending), 0);
        check("R7 no free on issue", 128'(count), 3);
        check("R6 unblocked", 128'(mem_blocked), 0);

        do_ack(3'd2);
        repeat (2) tick();
        check("R8 early ack frees nothing", 128'(count), 3);
        do_ack(3'd0);
        repeat (2) tick();
        check("R8 head freed", 128'(count), 2);
        do_ack(3'd1);
        repeat (3) tick();
        check("R8 drained", 128'(count), 0);

        for (int i = 0; i < 7; i++) begin
            do_alloc(16'(20 + i), 3'((3 + i) % E));
            if (i == 5) check("R3 not full at 6", 128'(full), 0);
        end
        check("R3 full", 128'(full), 1);
        check("R3 count at full", 128'(count), 7);
        alloc_valid = 1; alloc_seq = 16'd27;
        tick();
        alloc_valid = 0;
        check("R3 alloc ignored", 128'(count), 7);

        squash_valid = 1; squash_seq = 16'd23;
        tick();
        squash_valid = 0;
        check("R9 squash count", 128'(count), 4);
        squash_valid = 1; squash_seq = 16'd23; alloc_valid = 1; alloc_seq = 16'd99;
        tick();
        squash_valid = 0; alloc_valid = 0;
        check("R9 alloc ignored during squash", 128'(count), 4);
        do_alloc(16'd30, 3'd7);
        check("R9 count after reuse", 128'(count), 5);

        do_write(3'd3, 32'h3000, 5'd8,  128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF);
        do_write(3'd4, 32'h3010, 5'd16, 128'hFEDC_BA98_7654_3210_0F1E_2D3C_4B5A_6978);
        do_write(3'd5, 32'h3020, 5'd2,  128'h5);
        do_write(3'd6, 32'h3030, 5'd0,  128'h0);
        do_write(3'd7, 32'h3040, 5'd4,  128'hDEAD_BEEF);
        do_commit(16'd30);
        check("R5 commit five", 128'(wb_pending_cnt), 5);
        repeat (8) tick();
        check("R5 all issued", 128'(wb_pending_cnt), 0);
        for (int i = 3; i < 8; i++) do_ack(3'(i));
        repeat (4) tick();
        check("R7 freed after acks", 128'(count), 0);
        check("R4 all requests seen", 128'(exp_q.size()), 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule